// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a processor's execute stage and a word-wide data memory. It takes an access request, forms the effective address from a base value and a signed 16-bit displacement, and turns it into a word address, a set of per-byte write enables and a lane-steered store word. It then takes the word the memory returns and reduces it to the register result. Byte, halfword and word loads are handled with sign or zero extension. Two partial-word loads merge memory bytes into the previous register contents so that an unaligned word can be assembled in two steps. An upper-immediate load builds its result from the displacement field alone.

Memory is big-endian: the byte at the lowest address of a word is its most significant byte. Halfword and word accesses whose address is not naturally aligned are refused. A refused access writes no memory lane and no register. The block is a short pipeline. The request is registered together with the memory command. The memory answers one cycle later with a registered read. The register result is registered one cycle after that.

Top module: `be_lane_aligner`

## Requirements
- R1: A request presented on `req_op` is sampled at a rising edge. `mem_addr`, `mem_we` and `mem_wdata` show it after that edge, and `res_data`, `res_wb` and `res_fault` show it after the second edge that follows. The effective address is `req_base` plus `req_imm` sign-extended. `mem_addr` is that address with its two low bits dropped, and `mem_rdata` must carry the addressed word one cycle after `mem_addr`. The op codes are: 0 idle, 1 signed byte load, 2 unsigned byte load, 3 signed halfword load, 4 unsigned halfword load, 5 word load, 6 left merge load, 7 right merge load, 8 byte store, 9 halfword store, 10 word store, 11 upper-immediate load. Codes 12 to 15 act as idle.
- R2: Byte order is big-endian. The byte at address offset k (the two low address bits) occupies word bits [31-8k:24-8k]. `mem_we` bit j enables word bits [8j+7:8j], so offset k is enabled by bit 3-k.
- R3: A signed byte load returns the addressed byte sign-extended (0xF9 gives 0xFFFFFFF9). An unsigned byte load zero-extends it (0x000000F9). Byte loads never fault.
- R4: A halfword load at an even offset k returns bytes k (upper) and k+1 (lower). The signed form sign-extends the halfword (bytes FF F9 give 0xFFFFFFF9) and the unsigned form zero-extends it (0x0000FFF9).
- R5: A word load at offset 0 returns the memory word unchanged.
- R6: A left merge load at offset k returns memory bytes k..3 in the top 4-k result bytes and keeps the low k bytes of the old register value. With memory F8 2E 9B 2F and old value 0xA8B234E2, offset 1 gives 0x2E9B2FE2 and offset 2 gives 0x9B2F34E2. It never faults.
- R7: A right merge load at offset k returns memory bytes 0..k in the low k+1 result bytes and keeps the upper 3-k bytes of the old value. With the same data, offset 1 gives 0xA8B2F82E and offset 2 gives 0xA8F82E9B. It never faults.
- R8: A byte store enables only lane bit 3-k and writes `req_rt[7:0]` there. A halfword store enables bits 3-k and 2-k, with `req_rt[15:8]` at offset k and `req_rt[7:0]` at k+1. A word store enables all four lanes in big-endian order. No store asserts `res_wb`.
- R9: A halfword access (op 3, 4 or 9) at an odd address, or a word access (op 5 or 10) at an address whose two low bits are not zero, sets `res_fault`. The faulting access clears every `mem_we` bit and `res_wb`, and `res_data` is 0. Memory is left unchanged.
- R10: The upper-immediate load returns `req_imm` in bits 31:16 with zeros below, sets `res_wb` and never faults.
- R11: A synchronous active-high reset clears every output to zero. An idle request asserts no write enable and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 4 | Access kind, encoded as in R1 |
| req_base | input | ADDR_W | Base address operand |
| req_imm | input | IMM_W | Signed displacement; upper-immediate value for op 11 |
| req_rt | input | DATA_W | Store data source register |
| req_old | input | DATA_W | Current value of the destination register (for merges) |
| mem_addr | output | ADDR_W-2 | Word address to memory |
| mem_we | output | DATA_W/8 | Per-byte write enables, bit j for bits [8j+7:8j] |
| mem_wdata | output | DATA_W | Lane-steered store word |
| mem_rdata | input | DATA_W | Registered read word from memory |
| res_data | output | DATA_W | Register result |
| res_wb | output | 1 | Register writeback enable |
| res_fault | output | 1 | Alignment fault flag |

## Verification
The bench builds the block with DATA_W=32 and ADDR_W=8, so the bench memory has 64 words. That is small enough to fill every word through the block's own word stores and to keep a full reference copy. Every load kind is then swept over all four byte offsets on sixteen distinct words, with each expected result derived by shifting and masking the reference word. The three store widths are swept over every offset and read back through the block, which covers the faulting stores that must leave memory untouched.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_LDB_S  = 4'd1,
    OP_LDB_U  = 4'd2,
    OP_LDH_S  = 4'd3,
    OP_LDH_U  = 4'd4,
    OP_LDW    = 4'd5,
    OP_LDW_HI = 4'd6,
    OP_LDW_LO = 4'd7,
    OP_STB    = 4'd8,
    OP_STH    = 4'd9,
    OP_STW    = 4'd10,
    OP_IMM_HI = 4'd11
  } op_e;

  function automatic logic is_store(op_e op);
    return (op == OP_STB) || (op == OP_STH) || (op == OP_STW);
  endfunction

  function automatic logic writes_reg(op_e op);
    case (op)
      OP_LDB_S, OP_LDB_U, OP_LDH_S, OP_LDH_U,
      OP_LDW, OP_LDW_HI, OP_LDW_LO, OP_IMM_HI: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lsa_agen.sv
module lsa_agen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFF_W  = 2
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign
);

  assign ea = base + ADDR_W'($signed(imm));

  always_comb begin
    case (op)
      OP_LDH_S, OP_LDH_U, OP_STH: misalign = ea[0];
      OP_LDW, OP_STW:             misalign = |ea[OFF_W-1:0];
      default:                    misalign = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  op_e               op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rt,
  input  logic              fault,
  output logic [DATA_W/8-1:0] we,
  output logic [DATA_W-1:0] wdata
);

  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int  HI   = DATA_W - 1 - 8 * i;
    localparam bit  EVEN = (i % 2) == 0;
    logic sel_b, sel_h;

    assign sel_b = (int'(off) == i);
    assign sel_h = sel_b || (int'(off) + 1 == i);

    assign we[LANES-1-i] = !fault &&
                           (((op == OP_STB) && sel_b) ||
                            ((op == OP_STH) && sel_h) ||
                             (op == OP_STW));

    if (EVEN) begin : g_even
      assign wdata[HI -: 8] = (op == OP_STB) ? rt[7:0] :
                              (op == OP_STH) ? rt[15:8] : rt[HI -: 8];
    end else begin : g_odd
      assign wdata[HI -: 8] = (op == OP_STB || op == OP_STH) ? rt[7:0] : rt[HI -: 8];
    end
  end

endmodule

// File: rtl/lsa_load_merge.sv
module lsa_load_merge
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFF_W  = 2
) (
  input  op_e               op,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] rdata,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);

  localparam int LANES = DATA_W / 8;
  localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(LANES - 1);

  logic [DATA_W-1:0] up_sh, dn_sh, merge_hi, merge_lo, imm_hi;
  logic [7:0]        pick_b;
  logic [15:0]       pick_h;

  assign up_sh  = rdata << {off, 3'b000};
  assign dn_sh  = rdata >> {TOP_OFF - off, 3'b000};
  assign pick_b = up_sh[DATA_W-1 -: 8];
  assign pick_h = up_sh[DATA_W-1 -: 16];
  assign imm_hi = {imm, {(DATA_W-IMM_W){1'b0}}};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    assign merge_hi[HI -: 8] = (int'(off) + i < LANES) ? up_sh[HI -: 8] : old_val[HI -: 8];
    assign merge_lo[HI -: 8] = (i >= LANES - 1 - int'(off)) ? dn_sh[HI -: 8] : old_val[HI -: 8];
  end

  always_comb begin
    case (op)
      OP_LDB_S:  result = DATA_W'($signed(pick_b));
      OP_LDB_U:  result = DATA_W'(pick_b);
      OP_LDH_S:  result = DATA_W'($signed(pick_h));
      OP_LDH_U:  result = DATA_W'(pick_h);
      OP_LDW:    result = rdata;
      OP_LDW_HI: result = merge_hi;
      OP_LDW_LO: result = merge_lo;
      OP_IMM_HI: result = imm_hi;
      default:   result = '0;
    endcase
  end

endmodule

// File: rtl/be_lane_aligner.sv
module be_lane_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [3:0]                            req_op,
  input  logic [ADDR_W-1:0]                     req_base,
  input  logic [IMM_W-1:0]                      req_imm,
  input  logic [DATA_W-1:0]                     req_rt,
  input  logic [DATA_W-1:0]                     req_old,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_addr,
  output logic [DATA_W/8-1:0]                   mem_we,
  output logic [DATA_W-1:0]                     mem_wdata,
  input  logic [DATA_W-1:0]                     mem_rdata,
  output logic [DATA_W-1:0]                     res_data,
  output logic                                  res_wb,
  output logic                                  res_fault
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  op_e               in_op;
  logic [ADDR_W-1:0] ea;
  logic              misalign;
  logic [LANES-1:0]  st_we;
  logic [DATA_W-1:0] st_data;

  assign in_op = op_e'(req_op);

  lsa_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_agen (
    .op(in_op), .base(req_base), .imm(req_imm), .ea(ea), .misalign(misalign)
  );

  lsa_store_steer #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_steer (
    .op(in_op), .off(ea[OFF_W-1:0]), .rt(req_rt), .fault(misalign),
    .we(st_we), .wdata(st_data)
  );

  // Stage 1: request registered alongside the memory command
  op_e               s1_op;
  logic [OFF_W-1:0]  s1_off;
  logic [DATA_W-1:0] s1_old;
  logic [IMM_W-1:0]  s1_imm;
  logic              s1_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op     <= OP_IDLE;
      s1_off    <= '0;
      s1_old    <= '0;
      s1_imm    <= '0;
      s1_fault  <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= '0;
      mem_wdata <= '0;
    end else begin
      s1_op     <= in_op;
      s1_off    <= ea[OFF_W-1:0];
      s1_old    <= req_old;
      s1_imm    <= req_imm;
      s1_fault  <= misalign;
      mem_addr  <= ea[ADDR_W-1:OFF_W];
      mem_we    <= st_we;
      mem_wdata <= st_data;
    end
  end

  // Stage 2: waits for the registered memory read
  op_e               s2_op;
  logic [OFF_W-1:0]  s2_off;
  logic [DATA_W-1:0] s2_old;
  logic [IMM_W-1:0]  s2_imm;
  logic              s2_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_op    <= OP_IDLE;
      s2_off   <= '0;
      s2_old   <= '0;
      s2_imm   <= '0;
      s2_fault <= 1'b0;
    end else begin
      s2_op    <= s1_op;
      s2_off   <= s1_off;
      s2_old   <= s1_old;
      s2_imm   <= s1_imm;
      s2_fault <= s1_fault;
    end
  end

  logic [DATA_W-1:0] ld_val;

  lsa_load_merge #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_merge (
    .op(s2_op), .off(s2_off), .old_val(s2_old), .rdata(mem_rdata),
    .imm(s2_imm), .result(ld_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_wb    <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_data  <= s2_fault ? '0 : ld_val;
      res_wb    <= writes_reg(s2_op) && !s2_fault;
      res_fault <= s2_fault;
    end
  end

  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst) res_fault |-> !res_wb); // R9
  AST_WE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ($countones(mem_we) == 0) || ($countones(mem_we) == 1) ||
    ($countones(mem_we) == 2) || ($countones(mem_we) == LANES)); // R8
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst) is_store(s2_op) |=> !res_wb); // R8
  AST_MERGE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (s2_op == OP_LDW_HI || s2_op == OP_LDW_LO) |=> !res_fault); // R6
  AST_IMM_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (s2_op == OP_IMM_HI) |=> (res_wb && res_data[DATA_W-IMM_W-1:0] == '0)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_op == 4'd0) |=> (mem_we == '0)); // R11

endmodule

// File: tb/sim_be_lane_aligner.sv
module sim_be_lane_aligner;
  import lsa_pkg::*;

  localparam int AW    = 8;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  req_op = 4'd0;
  logic [AW-1:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [31:0] req_rt = '0, req_old = '0;
  logic [AW-3:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata, mem_rdata, res_data;
  logic        res_wb, res_fault;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] bmem [WORDS];
  logic [31:0] rmem [WORDS];
  logic [3:0]  cap_we;

  always #10 clk = ~clk;

  be_lane_aligner #(.DATA_W(32), .ADDR_W(AW), .IMM_W(16)) u0 (
    .clk(clk), .rst(rst), .req_op(req_op), .req_base(req_base), .req_imm(req_imm),
    .req_rt(req_rt), .req_old(req_old), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .res_data(res_data),
    .res_wb(res_wb), .res_fault(res_fault)
  );

  always @(posedge clk) begin
    for (int j = 0; j < 4; j++)
      if (mem_we[j]) bmem[mem_addr][8*j +: 8] <= mem_wdata[8*j +: 8];
    mem_rdata <= bmem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(op_e op, logic [AW-1:0] base, logic [15:0] imm,
                       logic [31:0] rt, logic [31:0] old);
    @(negedge clk);
    req_op = op; req_base = base; req_imm = imm; req_rt = rt; req_old = old;
    @(posedge clk);
    @(negedge clk);
    cap_we = mem_we;
    req_op = 4'd0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(op_e op);
    case (op)
      OP_LDB_S, OP_LDB_U: return "R3 byte load";
      OP_LDH_S, OP_LDH_U: return "R4 halfword load";
      OP_LDW:             return "R5 word load";
      OP_LDW_HI:          return "R6 left merge";
      OP_LDW_LO:          return "R7 right merge";
      OP_IMM_HI:          return "R10 upper immediate";
      default:            return "R8 store";
    endcase
  endfunction

  function automatic logic exp_fault(op_e op, int k);
    case (op)
      OP_LDH_S, OP_LDH_U, OP_STH: return (k % 2) != 0;
      OP_LDW, OP_STW:             return k != 0;
      default:                    return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model(op_e op, int k, logic [31:0] w,
                                        logic [31:0] old, logic [15:0] imm);
    logic [31:0] b, h;
    int s;
    b = (w >> (8 * (3 - k))) & 32'hFF;
    h = (w >> (8 * (2 - k))) & 32'hFFFF;
    s = 8 * (3 - k);
    case (op)
      OP_LDB_S:  return b[7] ? (b | 32'hFFFFFF00) : b;
      OP_LDB_U:  return b;
      OP_LDH_S:  return h[15] ? (h | 32'hFFFF0000) : h;
      OP_LDH_U:  return h;
      OP_LDW:    return w;
      OP_LDW_HI: return (w << (8 * k)) | (old & ((32'h1 << (8 * k)) - 32'h1));
      OP_LDW_LO: return (w >> s) | (old & ~(32'hFFFFFFFF >> s));
      OP_IMM_HI: return {imm, 16'h0000};
      default:   return 32'h0;
    endcase
  endfunction

  task automatic run_load(op_e op, int w, int k, logic [15:0] imm_lui, logic [31:0] old);
    logic ef, ewb;
    logic [15:0] imm;
    imm = (op == OP_IMM_HI) ? imm_lui : 16'hFFFE;
    issue(op, AW'(w * 4 + k + 2), imm, 32'h0, old);
    ef  = exp_fault(op, k);
    ewb = !ef;
    chk({tag_of(op), " R9 fault flag"}, {31'b0, res_fault}, {31'b0, ef});
    chk({tag_of(op), " R9 writeback"}, {31'b0, res_wb}, {31'b0, ewb});
    if (ef) chk({tag_of(op), " R9 faulted data"}, res_data, 32'h0);
    else    chk(tag_of(op), res_data, model(op, k, rmem[w], old, imm));
  endtask

  task automatic read_word(int w, string tag);
    issue(OP_LDW, AW'(w * 4 + 1), 16'hFFFF, 32'h0, 32'h0);
    chk(tag, res_data, rmem[w]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset mem_we", {28'b0, mem_we}, 32'h0);
    chk("R11 reset mem_addr", {26'b0, mem_addr}, 32'h0);
    chk("R11 reset mem_wdata", mem_wdata, 32'h0);
    chk("R11 reset res_data", res_data, 32'h0);
    chk("R11 reset res_wb/fault", {30'b0, res_wb, res_fault}, 32'h0);
    rst = 1'b0;

    // fill every word with aligned word stores (R1 address arithmetic, R8)
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] v;
      v = 32'hF82E9B2F ^ (32'(i) * 32'h01030507);
      issue(OP_STW, AW'(i * 4 + 5), 16'hFFFB, v, 32'h0);
      rmem[i] = v;
      chk("R8 word store enables", {28'b0, cap_we}, 32'hF);
      chk("R8 store gives no writeback", {31'b0, res_wb}, 32'h0);
    end
    for (int i = 0; i < WORDS; i += 7) read_word(i, "R5 R1 fill readback");

    // fixed vectors on word 0 = F8 2E 9B 2F
    issue(OP_LDW_HI, 8'd1, 16'h0000, 32'h0, 32'hA8B234E2);
    chk("R6 left merge offset 1", res_data, 32'h2E9B2FE2);
    issue(OP_LDW_HI, 8'd3, 16'hFFFF, 32'h0, 32'hA8B234E2);
    chk("R6 left merge offset 2", res_data, 32'h9B2F34E2);
    issue(OP_LDW_LO, 8'd0, 16'h0001, 32'h0, 32'hA8B234E2);
    chk("R7 right merge offset 1", res_data, 32'hA8B2F82E);
    issue(OP_LDW_LO, 8'd0, 16'h0002, 32'h0, 32'hA8B234E2);
    chk("R7 right merge offset 2", res_data, 32'hA8F82E9B);
    issue(OP_LDB_S, 8'd0, 16'h0000, 32'h0, 32'h0);
    chk("R3 signed byte msb lane", res_data, 32'hFFFFFFF8);
    issue(OP_LDH_U, 8'd2, 16'h0000, 32'h0, 32'h0);
    chk("R4 unsigned half lower", res_data, 32'h00009B2F);

    // store sweep over all offsets
    for (int k = 0; k < 4; k++) begin
      int ws;
      logic [31:0] rt;
      logic [3:0] ewe;
      ws = 40 + k;
      rt = 32'hFF92822F ^ 32'(k * 16'h1111);
      issue(OP_STB, AW'(ws * 4 + k + 1), 16'hFFFF, rt, 32'h0);
      ewe = 4'b0001 << (3 - k);
      chk("R8 R2 byte store enable", {28'b0, cap_we}, {28'b0, ewe});
      rmem[ws] = (rmem[ws] & ~(32'hFF << (8 * (3 - k)))) | ((rt & 32'hFF) << (8 * (3 - k)));
      read_word(ws, "R8 byte store readback");
      issue(OP_STH, AW'(ws * 4 + k + 1), 16'hFFFF, rt, 32'h0);
      if (exp_fault(OP_STH, k)) begin
        chk("R9 misaligned half store enables", {28'b0, cap_we}, 32'h0);
        chk("R9 misaligned half store fault", {31'b0, res_fault}, 32'h1);
      end else begin
        ewe = 4'b0011 << (2 - k);
        chk("R8 half store enables", {28'b0, cap_we}, {28'b0, ewe});
        rmem[ws] = (rmem[ws] & ~(32'hFFFF << (8 * (2 - k)))) | ((rt & 32'hFFFF) << (8 * (2 - k)));
      end
      read_word(ws, "R8 R9 half store readback");
      issue(OP_STW, AW'(ws * 4 + k + 1), 16'hFFFF, ~rt, 32'h0);
      if (exp_fault(OP_STW, k)) begin
        chk("R9 misaligned word store enables", {28'b0, cap_we}, 32'h0);
        chk("R9 misaligned word store fault", {31'b0, res_fault}, 32'h1);
      end else begin
        rmem[ws] = ~rt;
      end
      chk("R8 store gives no writeback", {31'b0, res_wb}, 32'h0);
      read_word(ws, "R8 R9 word store readback");
    end

    // load sweep: every load kind at every offset on sixteen words
    for (int w = 0; w < 16; w++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] old;
        old = ~rmem[w] ^ 32'(w * 32'h00010203);
        run_load(OP_LDB_S, w, k, 16'h0, old);
        run_load(OP_LDB_U, w, k, 16'h0, old);
        run_load(OP_LDH_S, w, k, 16'h0, old);
        run_load(OP_LDH_U, w, k, 16'h0, old);
        run_load(OP_LDW, w, k, 16'h0, old);
        run_load(OP_LDW_HI, w, k, 16'h0, old);
        run_load(OP_LDW_LO, w, k, 16'h0, old);
        run_load(OP_IMM_HI, w, k, 16'hF9F2 ^ 16'(w * 16'h0101 + k), old);
      end

    // idle requests and unused codes
    issue(OP_IDLE, 8'd4, 16'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R11 idle enables", {28'b0, cap_we}, 32'h0);
    chk("R11 idle writeback", {31'b0, res_wb}, 32'h0);
    issue(op_e'(4'd13), 8'd4, 16'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk("R1 unused code enables", {28'b0, cap_we}, 32'h0);
    chk("R1 unused code writeback", {31'b0, res_wb}, 32'h0);
    read_word(1, "R11 idle leaves memory");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule